// File: doc/BRIEF.md
# Indirect Multi-RAM Access Port

This block gives a host a narrow register window onto a set of internal RAMs that have no address space of their own. The RAMs are two flow tables (one for fixed flow attributes, one for changing flow state), a number of bank RAMs and four per-port FIFO RAMs. The host reaches all of them through one shared staging area. It holds five 64-bit data words, a 17-bit byte-enable mask and a command register. Nothing moves between the staging area and a RAM until the host writes the command register.

To write, the host fills the data words, sets the byte-enable mask, then writes a command with the write flag set. To read, it writes a command with the write flag clear, polls until busy drops, then reads the five data words. The command names the target RAM and carries two index fields. Tables and banks are addressed by the flow index. FIFO RAMs are addressed by the entry index. Each command takes a fixed two cycles. A command that arrives while one is still in progress is dropped, and this is recorded in a sticky error flag.

Top module: `ind_ram_port`

## Requirements
- R1: After reset, busy and the error flag are 0, and every host register (data words, byte-enable, command, status) reads as zero.
- R2: A command-register write while busy is low raises busy at the next clock edge. Busy then stays high for exactly two cycles and falls on the second edge after that.
- R3: Writes to the data words or to the byte-enable register change no RAM. A RAM is changed only by an accepted command that has the write flag (command bit 31) set.
- R4: For table and FIFO targets, enable bit i (0 to 16) covers staging byte i, which is word i/8, bits 8*(i%8) upward. A byte whose bit is clear keeps its old RAM content. A mask of 0x1FFFF writes the whole 17-byte entry.
- R5: For bank targets, enable bit w (0 to 3) writes the whole 64-bit data word w. Enable bits 4 to 16 have no effect on a bank.
- R6: A read command loads all five data words in the edge where busy falls. Table and FIFO entries fill bytes 0 to 16 and the rest are zero. Bank entries fill words 0 to 3 and word 4 is zero. The byte-enable register is not changed.
- R7: Tables and banks are addressed by the flow index (command bits 11:0), and FIFO RAMs by the entry index (command bits 23:12). The index is taken modulo the RAM depth, and the other index field is ignored.
- R8: The target select (command bits 27:24) decodes as follows: 0 is the static table, 1 the dynamic table, 2+b bank b, and 4+p the FIFO of port p. Codes 8 to 15 name no RAM. A write to such a code changes nothing, and a read of it returns zeros. A write reaches only the selected RAM.
- R9: A command write while busy is high is ignored: the command register keeps its value and no access is made. It also sets an error flag that only reset clears.
- R10: Host register map: addresses 0 to 4 are data words 0 to 4, 5 is the byte-enable mask (bits 16:0, upper bits read 0), 6 is the command, and 7 is status (bit 0 busy, bit 1 error; writes ignored). Read data is registered and shows the register addressed in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | 3 | Host register address |
| reg_wdata | input | 64 | Host write data |
| reg_rdata | output | 64 | Registered host read data |
| busy | output | 1 | Command in progress |
| cmd_err | output | 1 | Sticky flag: a command was written while busy |

## Verification
The assertions take for granted that the host uses only the register window. Busy timing and rejection are judged purely from command writes and the busy level. The assertions do not assume that the host waits for busy to fall. The one exception is a data-word write during a read, which the host must avoid. The stimulus writes the staging area only while idle and issues overlapping commands only in the dedicated collision case. It fills every RAM entry before the first read, so no read ever returns uninitialised storage.

// File: rtl/irp_pkg.sv
package irp_pkg;
  localparam int WORDS     = 5;
  localparam int WORD_W    = 64;
  localparam int STAGE_W   = WORDS * WORD_W;
  localparam int BE_W      = 17;
  localparam int IDX_W     = 12;
  localparam int SEL_W     = 4;
  localparam int TBL_COUNT = 2;
  localparam int BANK_WORDS = 4;

  localparam logic [2:0] ADDR_BE   = 3'd5;
  localparam logic [2:0] ADDR_CTL  = 3'd6;
  localparam logic [2:0] ADDR_STAT = 3'd7;

  typedef struct packed {
    logic             wr;
    logic [SEL_W-1:0] sel;
    logic [IDX_W-1:0] entry;
    logic [IDX_W-1:0] flow;
  } cmd_t;

  typedef enum logic [1:0] {PH_IDLE, PH_ACCESS, PH_FINISH} phase_t;
endpackage

// File: rtl/irp_bytemem.sv
module irp_bytemem #(
  parameter int NBYTES = 17,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                we,
  input  logic                re,
  input  logic [NBYTES-1:0]   be,
  input  logic [AW-1:0]       addr,
  input  logic [NBYTES*8-1:0] wdata,
  output logic [NBYTES*8-1:0] rdata
);
  logic [NBYTES*8-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int b = 0; b < NBYTES; b++) begin
        if (be[b]) mem[addr][b*8 +: 8] <= wdata[b*8 +: 8];
      end
    end
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/irp_seq.sv
module irp_seq import irp_pkg::*; (
  input  logic clk,
  input  logic rst,
  input  logic ctl_hit,
  output logic accept,
  output logic access,
  output logic finish,
  output logic busy,
  output logic err
);
  phase_t ph;

  assign accept = ctl_hit && (ph == PH_IDLE);
  assign access = (ph == PH_ACCESS);
  assign finish = (ph == PH_FINISH);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph   <= PH_IDLE;
      busy <= 1'b0;
      err  <= 1'b0;
    end else begin
      if (ctl_hit && ph != PH_IDLE) err <= 1'b1;
      case (ph)
        PH_IDLE:   if (accept) begin ph <= PH_ACCESS; busy <= 1'b1; end
        PH_ACCESS: ph <= PH_FINISH;
        default:   begin ph <= PH_IDLE; busy <= 1'b0; end
      endcase
    end
  end

  assert_launch_R2: assert property (@(posedge clk) disable iff (rst)
    (ctl_hit && !busy) |=> busy);
  assert_two_cycles_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |=> busy ##1 !busy);
  assert_reject_flag_R9: assert property (@(posedge clk) disable iff (rst)
    (ctl_hit && busy) |=> err);
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    err |=> err);
endmodule

// File: rtl/ind_ram_port.sv
module ind_ram_port import irp_pkg::*; #(
  parameter int TBL_DEPTH  = 16,
  parameter int BANK_COUNT = 2,
  parameter int BANK_DEPTH = 16,
  parameter int FIFO_COUNT = 4,
  parameter int FIFO_DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [63:0] reg_wdata,
  output logic [63:0] reg_rdata,
  output logic        busy,
  output logic        cmd_err
);
  localparam int TBL_AW     = $clog2(TBL_DEPTH);
  localparam int BANK_AW    = $clog2(BANK_DEPTH);
  localparam int FIFO_AW    = $clog2(FIFO_DEPTH);
  localparam int ENT_BITS   = BE_W * 8;
  localparam int BANK_BYTES = BANK_WORDS * 8;
  localparam int BANK_BITS  = BANK_BYTES * 8;
  localparam int BANK_BASE  = TBL_COUNT;
  localparam int FIFO_BASE  = BANK_BASE + BANK_COUNT;
  localparam int N_TGT      = FIFO_BASE + FIFO_COUNT;

  logic [WORD_W-1:0]  stage_q [WORDS];
  logic [BE_W-1:0]    be_q;
  cmd_t               ctl_q;
  logic [63:0]        rdata_q;
  logic [STAGE_W-1:0] stage_flat;
  logic [STAGE_W-1:0] rd_flat;
  logic [BANK_BYTES-1:0] bank_be;
  logic [N_TGT-1:0]   tgt_we;
  logic accept, access, finish, seq_busy, seq_err;
  logic ctl_hit;

  logic [ENT_BITS-1:0]  tbl_q  [TBL_COUNT];
  logic [BANK_BITS-1:0] bank_q [BANK_COUNT];
  logic [ENT_BITS-1:0]  fifo_q [FIFO_COUNT];

  assign ctl_hit = reg_wr && (reg_addr == ADDR_CTL);

  irp_seq u_seq (
    .clk(clk), .rst(rst), .ctl_hit(ctl_hit), .accept(accept),
    .access(access), .finish(finish), .busy(seq_busy), .err(seq_err)
  );

  always_comb begin
    for (int w = 0; w < WORDS; w++) stage_flat[w*WORD_W +: WORD_W] = stage_q[w];
    for (int i = 0; i < BANK_BYTES; i++) bank_be[i] = be_q[i/8];
  end

  // host side staging registers; a finished read overwrites the data words
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < WORDS; w++) stage_q[w] <= '0;
      be_q  <= '0;
      ctl_q <= '0;
    end else begin
      if (reg_wr && reg_addr < 3'(WORDS)) stage_q[reg_addr] <= reg_wdata;
      if (reg_wr && reg_addr == ADDR_BE) be_q <= reg_wdata[BE_W-1:0];
      if (accept) begin
        ctl_q.wr    <= reg_wdata[31];
        ctl_q.sel   <= reg_wdata[27:24];
        ctl_q.entry <= reg_wdata[23:12];
        ctl_q.flow  <= reg_wdata[11:0];
      end
      if (finish && !ctl_q.wr) begin
        for (int w = 0; w < WORDS; w++) stage_q[w] <= rd_flat[w*WORD_W +: WORD_W];
      end
    end
  end

  // target memories
  for (genvar t = 0; t < TBL_COUNT; t++) begin : g_tbl
    assign tgt_we[t] = access && ctl_q.wr && (ctl_q.sel == SEL_W'(t));
    irp_bytemem #(.NBYTES(BE_W), .DEPTH(TBL_DEPTH)) u_mem (
      .clk(clk), .we(tgt_we[t]), .re(access), .be(be_q),
      .addr(TBL_AW'(ctl_q.flow % TBL_DEPTH)),
      .wdata(stage_flat[ENT_BITS-1:0]), .rdata(tbl_q[t])
    );
  end

  for (genvar b = 0; b < BANK_COUNT; b++) begin : g_bank
    assign tgt_we[BANK_BASE+b] = access && ctl_q.wr && (ctl_q.sel == SEL_W'(BANK_BASE+b));
    irp_bytemem #(.NBYTES(BANK_BYTES), .DEPTH(BANK_DEPTH)) u_mem (
      .clk(clk), .we(tgt_we[BANK_BASE+b]), .re(access), .be(bank_be),
      .addr(BANK_AW'(ctl_q.flow % BANK_DEPTH)),
      .wdata(stage_flat[BANK_BITS-1:0]), .rdata(bank_q[b])
    );
  end

  for (genvar p = 0; p < FIFO_COUNT; p++) begin : g_fifo
    assign tgt_we[FIFO_BASE+p] = access && ctl_q.wr && (ctl_q.sel == SEL_W'(FIFO_BASE+p));
    irp_bytemem #(.NBYTES(BE_W), .DEPTH(FIFO_DEPTH)) u_mem (
      .clk(clk), .we(tgt_we[FIFO_BASE+p]), .re(access), .be(be_q),
      .addr(FIFO_AW'(ctl_q.entry % FIFO_DEPTH)),
      .wdata(stage_flat[ENT_BITS-1:0]), .rdata(fifo_q[p])
    );
  end

  // read-back selection, zero-extended to the staging width
  always_comb begin
    rd_flat = '0;
    for (int t = 0; t < TBL_COUNT; t++)
      if (ctl_q.sel == SEL_W'(t)) rd_flat[ENT_BITS-1:0] = tbl_q[t];
    for (int b = 0; b < BANK_COUNT; b++)
      if (ctl_q.sel == SEL_W'(BANK_BASE+b)) rd_flat[BANK_BITS-1:0] = bank_q[b];
    for (int p = 0; p < FIFO_COUNT; p++)
      if (ctl_q.sel == SEL_W'(FIFO_BASE+p)) rd_flat[ENT_BITS-1:0] = fifo_q[p];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (reg_addr == ADDR_BE)   rdata_q <= 64'(be_q);
    else if (reg_addr == ADDR_CTL)  rdata_q <= {32'b0, ctl_q.wr, 3'b0, ctl_q.sel, ctl_q.entry, ctl_q.flow};
    else if (reg_addr == ADDR_STAT) rdata_q <= {62'b0, seq_err, seq_busy};
    else                            rdata_q <= stage_q[reg_addr];
  end

  assign reg_rdata = rdata_q;
  assign busy      = seq_busy;
  assign cmd_err   = seq_err;

  assert_commit_only_busy_R3: assert property (@(posedge clk) disable iff (rst)
    (|tgt_we) |-> seq_busy);
  assert_single_target_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tgt_we));
  assert_ctl_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    seq_busy |=> $stable(ctl_q));
endmodule

// File: tb/ind_ram_port_tb.sv
module ind_ram_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        busy, cmd_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [63:0] seed = 64'h0DDC0FFEE1234567;
  logic [7:0]  mdl [8][DEPTH][40];
  logic [63:0] sw [5];

  always #(CLK_PERIOD/2) clk = ~clk;

  ind_ram_port u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .cmd_err(cmd_err)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] rnd();
    seed = seed * 64'h5851F42D4C957F2D + 64'h14057B7EF767814F;
    return seed ^ (seed >> 29);
  endfunction

  function automatic logic [63:0] ctl_of(input bit wr, input int sel, input int entry, input int flow);
    return {32'b0, wr, 3'b0, 4'(sel), 12'(entry), 12'(flow)};
  endfunction

  task automatic wr_reg(input logic [2:0] a, input logic [63:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [63:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic do_cmd(input logic [63:0] c);
    wr_reg(3'd6, c);
    check("R2 busy after launch", 64'(busy), 64'd1);
    @(negedge clk);
    check("R2 busy second cycle", 64'(busy), 64'd1);
    @(negedge clk);
    check("R2 busy cleared", 64'(busy), 64'd0);
  endtask

  task automatic load_stage();
    for (int w = 0; w < 5; w++) begin
      sw[w] = rnd();
      wr_reg(3'(w), sw[w]);
    end
  endtask

  task automatic model_write(input int sel, input int entry, input int flow, input logic [16:0] be);
    int idx;
    if (sel >= 8) return;
    idx = (sel >= 4) ? entry % DEPTH : flow % DEPTH;
    if (sel == 2 || sel == 3) begin
      for (int w = 0; w < 4; w++)
        if (be[w]) for (int k = 0; k < 8; k++) mdl[sel][idx][w*8+k] = sw[w][k*8 +: 8];
    end else begin
      for (int i = 0; i < 17; i++)
        if (be[i]) mdl[sel][idx][i] = sw[i/8][(i%8)*8 +: 8];
    end
  endtask

  task automatic host_write(input int sel, input int entry, input int flow, input logic [16:0] be);
    load_stage();
    wr_reg(3'd5, 64'(be));
    do_cmd(ctl_of(1'b1, sel, entry, flow));
    model_write(sel, entry, flow, be);
  endtask

  task automatic host_read(input string tag, input int sel, input int entry, input int flow);
    logic [63:0] v, e;
    int idx;
    idx = (sel >= 4) ? entry % DEPTH : flow % DEPTH;
    do_cmd(ctl_of(1'b0, sel, entry, flow));
    for (int w = 0; w < 5; w++) begin
      rd_reg(3'(w), v);
      e = '0;
      if (sel < 8) for (int k = 0; k < 8; k++) e[k*8 +: 8] = mdl[sel][idx][w*8+k];
      check(tag, v, e);
    end
  endtask

  initial begin
    logic [63:0] v;
    logic [16:0] pats [6];
    int idx, alias_i;
    pats[0] = 17'h00001; pats[1] = 17'h10000; pats[2] = 17'h0A5A5;
    pats[3] = 17'h1F0F0; pats[4] = 17'h00000; pats[5] = 17'h1FFF0;
    for (int s = 0; s < 8; s++)
      for (int i = 0; i < DEPTH; i++)
        for (int b = 0; b < 40; b++) mdl[s][i][b] = 8'h00;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1 busy", 64'(busy), 64'd0);
    check("R1 err", 64'(cmd_err), 64'd0);
    for (int a = 0; a < 8; a++) begin
      rd_reg(3'(a), v);
      check("R1 register zero", v, 64'd0);
    end

    // R10: register map
    wr_reg(3'd5, 64'hFFFF_FFFF_FFFF_FFFF);
    rd_reg(3'd5, v); check("R10 enable width", v, 64'h1FFFF);
    wr_reg(3'd7, 64'hFFFF_FFFF_FFFF_FFFF);
    rd_reg(3'd7, v); check("R10 status write ignored", v, 64'd0);
    wr_reg(3'd3, 64'hA5A5_0000_1234_5678);
    rd_reg(3'd3, v); check("R10 data word", v, 64'hA5A5_0000_1234_5678);

    // fill every entry of every target, then read all back (R4 R5 R6 R8)
    for (int s = 0; s < 8; s++)
      for (int i = 0; i < DEPTH; i++) host_write(s, i, i, 17'h1FFFF);
    for (int s = 0; s < 8; s++)
      for (int i = 0; i < DEPTH; i++) host_read("R6 full fill readback", s, i, i);
    rd_reg(3'd5, v); check("R6 enable untouched by read", v, 64'h1FFFF);

    // partial masks with aliased indices (R4 R5 R7)
    for (int s = 0; s < 8; s++) begin
      for (int p = 0; p < 6; p++) begin
        idx = (p*5 + s) % DEPTH;
        alias_i = idx + DEPTH*(p+1);
        if (s >= 4) begin
          host_write(s, alias_i, int'(rnd() % 4096), pats[p]);
          host_read("R4 R7 fifo partial", s, idx, int'(rnd() % 4096));
          host_read("R7 fifo neighbour", s, (idx+1) % DEPTH, idx);
        end else begin
          host_write(s, int'(rnd() % 4096), alias_i, pats[p]);
          host_read(s < 2 ? "R4 R7 table partial" : "R5 R7 bank partial", s, int'(rnd() % 4096), idx);
          host_read("R7 table/bank neighbour", s, idx, (idx+1) % DEPTH);
        end
      end
    end

    // R3: staging alone commits nothing
    load_stage();
    wr_reg(3'd5, 64'h1FFFF);
    host_read("R3 staging not committed", 0, 0, 3);
    host_read("R3 staging not committed fifo", 5, 3, 0);

    // R8: unused selects
    host_write(9, 2, 2, 17'h1FFFF);
    host_write(15, 2, 2, 17'h1FFFF);
    host_read("R8 unused select reads zero", 12, 2, 2);
    for (int s = 0; s < 8; s++) host_read("R8 unused select wrote nothing", s, 2, 2);

    // R9: command while busy
    check("R9 err clear before collision", 64'(cmd_err), 64'd0);
    load_stage();
    wr_reg(3'd5, 64'h1FFFF);
    wr_reg(3'd6, ctl_of(1'b1, 1, 0, 4));
    wr_reg(3'd6, ctl_of(1'b1, 1, 0, 5));
    @(negedge clk);
    check("R9 busy cleared after first", 64'(busy), 64'd0);
    model_write(1, 0, 4, 17'h1FFFF);
    check("R9 err set", 64'(cmd_err), 64'd1);
    rd_reg(3'd6, v); check("R9 command kept", v, ctl_of(1'b1, 1, 0, 4));
    rd_reg(3'd7, v); check("R9 status err bit", v, 64'd2);
    host_read("R9 first command done", 1, 0, 4);
    host_read("R9 rejected command no effect", 1, 0, 5);
    check("R9 err sticky", 64'(cmd_err), 64'd1);

    done = 1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=%h exp=%h", 64'd0, 64'd1);
    end
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule